// File: doc/BRIEF.md
# Sub-Word Write Coalescing Bridge

This block connects a host bus that makes 8-, 16- and 32-bit register accesses to a peripheral register file that only takes aligned 32-bit accesses. Narrow writes become a 32-bit read of the containing word followed by a 32-bit write of the merged word. Narrow reads become a 32-bit read, and the addressed lane is returned right-justified.

Two 16-bit register pairs share a 32-bit word and must never be written separately in a short window. The block-size/block-count pair and the transfer-mode halfword are therefore held in two shadow words inside the bridge. A halfword write to the command register releases them. The pending block word goes out first, then the command word carrying the held transfer mode. While a shadow is valid, halfword reads of its registers are answered from the shadow.

When the card clock is slow (at most 400 kHz, or stopped), every downstream write is followed by a quiet interval. During that interval the bridge issues no downstream access and accepts no request.

Top module: `subwordWriteBridge`

## Requirements
- R1: A byte write (size code 0) reads the aligned word (address with bits 1:0 cleared), replaces only the byte lane at bit offset 8*addr[1:0] and writes the word back: one downstream read, then one write.
- R2: A halfword write (size code 1) to any address other than 0x04, 0x06, 0x0C or 0x0E is a read-modify-write of the aligned word, replacing the 16-bit lane at bit offset 8*addr[1:0].
- R3: A word write (size code 2) produces exactly one downstream write of the request data to the aligned address, with no downstream read.
- R4: A halfword write to 0x04 (block size) or 0x06 (block count) never writes downstream. It merges into the block shadow and marks it valid. The old word comes from a downstream read only when the shadow is not yet valid; otherwise the merge uses the shadow and there is no downstream access.
- R5: A halfword write to 0x0C (transfer mode) never writes downstream. It reads word 0x0C, merges the halfword into the low lane and stores the result in the command shadow, which becomes valid.
- R6: A halfword write to 0x0E (command) first writes the block shadow to 0x04 if it is valid. It then writes to 0x0C the command shadow with its upper lane replaced by the command halfword. Both shadow-valid flags end up clear, and the command shadow keeps its last content.
- R7: A halfword read of 0x0C returns the command shadow's low lane while that shadow is valid. A halfword read of 0x04 or 0x06 returns the matching lane of the block shadow while it is valid. Neither case makes a downstream access. Every other read returns the lane taken from one downstream read of the aligned word.
- R8: With 0 < cardHz <= 400000, after each downstream write there is no downstream access for ceil(4e6/cardHz) microseconds (CYC_PER_US clock cycles each), and reqReady rises exactly that many cycles plus one after the write cycle.
- R9: With cardHz = 0 the quiet interval after each downstream write is 10 microseconds.
- R10: With cardHz > 400000 there is no quiet interval: reqReady is high the cycle after the last write, and the block flush and command write go out in consecutive cycles.
- R11: After reset, reqReady is high, dnValid and rspValid are low, and both shadows are invalid with zero contents.
- R12: A request is accepted when reqValid and reqReady are both high. reqReady stays low until the request is done, and each request yields exactly one single-cycle rspValid pulse (read data in rspRdata).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Bridge can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqAddr | input | AW | Byte address of the access |
| reqWdata | input | 32 | Write data, right-justified |
| rspValid | output | 1 | Request completed (one cycle) |
| rspRdata | output | 32 | Read data, right-justified |
| cardHz | input | 32 | Current card clock frequency in Hz |
| dnValid | output | 1 | Downstream access strobe |
| dnWrite | output | 1 | Downstream access is a write |
| dnAddr | output | AW | Downstream word-aligned address |
| dnWdata | output | 32 | Downstream write data |
| dnRdata | input | 32 | Downstream read data, valid the cycle after a read strobe |

## Verification
A shadow-valid flag in the wrong state shows up at the downstream port within the same request. A stale flag either adds a read before a block or transfer-mode merge or removes one. It can also answer a halfword read with no downstream access, or drop or add the block flush in front of a command write. A corrupted shadow word shows up at the next command write, in the flushed block word or in the low lane of the command word. A timer fault shows up as a reqReady rising edge at the wrong cycle count after the write, so each spacing case is checked for its exact cycle number.

// File: rtl/mergeBridgePkg.sv
package mergeBridgePkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath, at most one action per cycle
  typedef struct packed {
    logic capture;
    logic fetch;
    logic wrWord;
    logic flush;
    logic cmdWrite;
    logic mergeToWord;
    logic blkFromRd;
    logic blkFromShadow;
    logic cmdFromRd;
    logic rspFromRd;
    logic rspFromShadow;
  } ctrlStrobe_t;

  // classification of the latched request, datapath to control
  typedef struct packed {
    logic isWrite;
    logic isWord;
    logic isBlkHalf;
    logic isXferHalf;
    logic isCmdHalf;
    logic shadowHit;
    logic blkValid;
  } reqClass_t;

  function automatic logic [WORD_W-1:0] laneMask(logic [1:0] sz, logic [1:0] off);
    logic [WORD_W-1:0] base;
    case (sz)
      SZ_BYTE: base = 32'h0000_00FF;
      SZ_HALF: base = 32'h0000_FFFF;
      default: base = '1;
    endcase
    return base << {off, 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] mergeLane(logic [WORD_W-1:0] oldWord,
      logic [WORD_W-1:0] val, logic [1:0] sz, logic [1:0] off);
    logic [WORD_W-1:0] m;
    m = laneMask(sz, off);
    return (oldWord & ~m) | ((val << {off, 3'b000}) & m);
  endfunction

  function automatic logic [WORD_W-1:0] pickLane(logic [WORD_W-1:0] word,
      logic [1:0] sz, logic [1:0] off);
    return (word & laneMask(sz, off)) >> {off, 3'b000};
  endfunction

endpackage

// File: rtl/spacingTimer.sv
module spacingTimer #(
  parameter int CYC_PER_US  = 50,
  parameter int SLOW_HZ     = 400000,
  parameter int GAP_PERIODS = 4,
  parameter int ZERO_GAP_US = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] cardHz,
  output logic        busy
);
  localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int UW = $clog2(ZERO_GAP_US + 1);
  localparam logic [CW-1:0] LAST_CYC = CW'(CYC_PER_US - 1);
  localparam logic [UW-1:0] LAST_US  = UW'(ZERO_GAP_US - 1);
  localparam logic [31:0]   TARGET   = 32'(GAP_PERIODS * 1000000);
  localparam logic [31:0]   SLOW_LIM = 32'(SLOW_HZ);

  logic [CW-1:0] cycCnt;
  logic [UW-1:0] usCnt;
  logic [31:0]   acc, hzQ, accNext;
  logic          tick;

  assign tick    = busy && (cycCnt == LAST_CYC);
  assign accNext = acc + hzQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cycCnt <= '0;
      usCnt  <= '0;
      acc    <= '0;
      hzQ    <= '0;
    end else if (start) begin
      busy   <= (cardHz <= SLOW_LIM);
      cycCnt <= '0;
      usCnt  <= '0;
      acc    <= '0;
      hzQ    <= cardHz;
    end else if (busy) begin
      if (tick) begin
        cycCnt <= '0;
        if (hzQ == '0) begin
          if (usCnt == LAST_US) busy <= 1'b0;
          else                  usCnt <= usCnt + 1'b1;
        end else if (accNext >= TARGET) begin
          busy <= 1'b0;
        end else begin
          acc <= accNext;
        end
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  // a new write never lands inside a running quiet interval
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);
  // fast card clock: no quiet interval at all
  p_fast_skip_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && cardHz > SLOW_LIM) |=> !busy);
  // zero clock mode ends only at a microsecond boundary
  p_zero_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hzQ == '0 && !start && !tick) |=> busy);

endmodule

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import mergeBridgePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  reqClass_t   cls,
  input  logic        timerBusy,
  output logic        reqReady,
  output ctrlStrobe_t stb,
  output logic        dnValid,
  output logic        dnWrite
);
  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_FETCH, S_MERGE, S_WRITE, S_FLUSH, S_CMDWR
  } state_e;

  state_e state, nextState;

  assign reqReady = (state == S_IDLE) && !timerBusy;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (reqValid && reqReady) begin
        stb.capture = 1'b1;
        nextState   = S_DECODE;
      end
      S_DECODE: begin
        if (!cls.isWrite) begin
          if (cls.shadowHit) begin
            stb.rspFromShadow = 1'b1;
            nextState         = S_IDLE;
          end else begin
            nextState = S_FETCH;
          end
        end else if (cls.isWord) begin
          nextState = S_WRITE;
        end else if (cls.isCmdHalf) begin
          nextState = cls.blkValid ? S_FLUSH : S_CMDWR;
        end else if (cls.isBlkHalf && cls.blkValid) begin
          stb.blkFromShadow = 1'b1;
          nextState         = S_IDLE;
        end else begin
          nextState = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.fetch = 1'b1;
        nextState = S_MERGE;
      end
      S_MERGE: begin
        nextState = S_IDLE;
        if (!cls.isWrite)       stb.rspFromRd = 1'b1;
        else if (cls.isBlkHalf) stb.blkFromRd = 1'b1;
        else if (cls.isXferHalf) stb.cmdFromRd = 1'b1;
        else begin
          stb.mergeToWord = 1'b1;
          nextState       = S_WRITE;
        end
      end
      S_WRITE: begin
        stb.wrWord = 1'b1;
        nextState  = S_IDLE;
      end
      S_FLUSH: begin
        stb.flush = 1'b1;
        nextState = S_CMDWR;
      end
      S_CMDWR: if (!timerBusy) begin
        stb.cmdWrite = 1'b1;
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign dnWrite = stb.wrWord | stb.flush | stb.cmdWrite;
  assign dnValid = dnWrite | stb.fetch;

  p_ready_only_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !reqReady);
  p_quiet_in_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerBusy |-> !dnValid);
  p_flush_then_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FLUSH) |=> (state == S_CMDWR));

endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import mergeBridgePkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] BLKSZ_OFF  = 8'h04,
  parameter logic [AW-1:0] BLKCNT_OFF = 8'h06,
  parameter logic [AW-1:0] XFER_OFF   = 8'h0C,
  parameter logic [AW-1:0] CMD_OFF    = 8'h0E
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [AW-1:0]     reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [WORD_W-1:0] dnRdata,
  output reqClass_t         cls,
  output logic [AW-1:0]     dnAddr,
  output logic [WORD_W-1:0] dnWdata,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspRdata
);
  localparam logic [AW-1:0] BLK_WORD = {BLKSZ_OFF[AW-1:2], 2'b00};

  logic              writeQ;
  logic [1:0]        sizeQ;
  logic [AW-1:0]     addrQ;
  logic [WORD_W-1:0] dataQ, wordQ, blkShadow, cmdShadow, cmdMerged;
  logic              blkValid, cmdValid;
  logic              isHalf, atBlk, atXfer, atCmd;

  assign isHalf = (sizeQ == SZ_HALF);
  assign atBlk  = (addrQ == BLKSZ_OFF) || (addrQ == BLKCNT_OFF);
  assign atXfer = (addrQ == XFER_OFF);
  assign atCmd  = (addrQ == CMD_OFF);

  assign cls.isWrite    = writeQ;
  assign cls.isWord     = (sizeQ == SZ_WORD);
  assign cls.isBlkHalf  = isHalf && atBlk;
  assign cls.isXferHalf = isHalf && atXfer;
  assign cls.isCmdHalf  = isHalf && atCmd;
  assign cls.shadowHit  = isHalf && ((atXfer && cmdValid) || (atBlk && blkValid));
  assign cls.blkValid   = blkValid;

  assign cmdMerged = mergeLane(cmdShadow, dataQ, sizeQ, addrQ[1:0]);

  always_comb begin
    dnAddr  = {addrQ[AW-1:2], 2'b00};
    dnWdata = wordQ;
    if (stb.flush) begin
      dnAddr  = BLK_WORD;
      dnWdata = blkShadow;
    end else if (stb.cmdWrite) begin
      dnWdata = cmdMerged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeQ    <= 1'b0;
      sizeQ     <= '0;
      addrQ     <= '0;
      dataQ     <= '0;
      wordQ     <= '0;
      blkShadow <= '0;
      cmdShadow <= '0;
      blkValid  <= 1'b0;
      cmdValid  <= 1'b0;
      rspValid  <= 1'b0;
      rspRdata  <= '0;
    end else begin
      rspValid <= stb.rspFromRd | stb.rspFromShadow | stb.blkFromRd |
                  stb.blkFromShadow | stb.cmdFromRd | stb.wrWord | stb.cmdWrite;
      if (stb.capture) begin
        writeQ <= reqWrite;
        sizeQ  <= reqSize;
        addrQ  <= reqAddr;
        dataQ  <= reqWdata;
        wordQ  <= reqWdata;
      end
      if (stb.mergeToWord) wordQ <= mergeLane(dnRdata, dataQ, sizeQ, addrQ[1:0]);
      if (stb.rspFromRd)   rspRdata <= pickLane(dnRdata, sizeQ, addrQ[1:0]);
      if (stb.rspFromShadow)
        rspRdata <= pickLane(atXfer ? cmdShadow : blkShadow, sizeQ, addrQ[1:0]);
      if (stb.blkFromRd) begin
        blkShadow <= mergeLane(dnRdata, dataQ, sizeQ, addrQ[1:0]);
        blkValid  <= 1'b1;
      end
      if (stb.blkFromShadow) blkShadow <= mergeLane(blkShadow, dataQ, sizeQ, addrQ[1:0]);
      if (stb.cmdFromRd) begin
        cmdShadow <= mergeLane(dnRdata, dataQ, sizeQ, addrQ[1:0]);
        cmdValid  <= 1'b1;
      end
      if (stb.flush) blkValid <= 1'b0;
      if (stb.cmdWrite) begin
        cmdShadow <= cmdMerged;
        cmdValid  <= 1'b0;
      end
    end
  end

  p_cmd_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmdWrite |=> (!blkValid && !cmdValid));
  p_blk_marked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.blkFromRd || stb.blkFromShadow) |=> blkValid);
  p_xfer_marked_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmdFromRd |=> cmdValid);
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/subwordWriteBridge.sv
module subwordWriteBridge
  import mergeBridgePkg::*;
#(
  parameter int AW          = 8,
  parameter int CYC_PER_US  = 50,
  parameter int SLOW_HZ     = 400000,
  parameter int GAP_PERIODS = 4,
  parameter int ZERO_GAP_US = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [1:0]    reqSize,
  input  logic [AW-1:0] reqAddr,
  input  logic [31:0]   reqWdata,
  output logic          rspValid,
  output logic [31:0]   rspRdata,
  input  logic [31:0]   cardHz,
  output logic          dnValid,
  output logic          dnWrite,
  output logic [AW-1:0] dnAddr,
  output logic [31:0]   dnWdata,
  input  logic [31:0]   dnRdata
);
  ctrlStrobe_t stb;
  reqClass_t   cls;
  logic        timerBusy;

  bridgeCtrl u_ctrl (
    .clk, .rstN, .reqValid, .cls, .timerBusy,
    .reqReady, .stb, .dnValid, .dnWrite
  );

  bridgeDatapath #(.AW(AW)) u_dp (
    .clk, .rstN, .stb, .reqWrite, .reqSize, .reqAddr, .reqWdata,
    .dnRdata, .cls, .dnAddr, .dnWdata, .rspValid, .rspRdata
  );

  spacingTimer #(
    .CYC_PER_US(CYC_PER_US), .SLOW_HZ(SLOW_HZ),
    .GAP_PERIODS(GAP_PERIODS), .ZERO_GAP_US(ZERO_GAP_US)
  ) u_gap (
    .clk, .rstN, .start(dnValid && dnWrite), .cardHz, .busy(timerBusy)
  );

endmodule

// File: tb/subwordWriteBridge_test.sv
module subwordWriteBridge_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [7:0]  reqAddr = 8'h00;
  logic [31:0] reqWdata = '0, cardHz = 32'd25000000;
  logic        reqReady, rspValid, dnValid, dnWrite;
  logic [31:0] rspRdata, dnWdata, dnRdata;
  logic [7:0]  dnAddr;

  subwordWriteBridge uut (.*);

  always #10 clk = ~clk;

  // peripheral register file: read data valid the cycle after the strobe
  logic [31:0] mem [64];
  logic [31:0] rdQ = '0;
  assign dnRdata = rdQ;
  function automatic logic [31:0] initWord(int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
  endfunction
  initial for (int i = 0; i < 64; i++) mem[i] = initWord(i);
  always @(posedge clk) if (dnValid) begin
    if (dnWrite) mem[dnAddr[7:2]] <= dnWdata;
    else         rdQ <= mem[dnAddr[7:2]];
  end

  // downstream monitor
  int cyc = 0, nRd = 0, nWr = 0;
  int lastWrCyc = 0, prevWrCyc = 0;
  logic [7:0]  lastWrAddr = '0, prevWrAddr = '0;
  logic [31:0] lastWrData = '0, prevWrData = '0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (dnValid) begin
    if (dnWrite) begin
      nWr++;
      prevWrCyc = lastWrCyc; prevWrAddr = lastWrAddr; prevWrData = lastWrData;
      lastWrCyc = cyc; lastWrAddr = dnAddr; lastWrData = dnWdata;
    end else nRd++;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  int rdBase, wrBase;
  logic readyAfterAccept;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic w, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
    while (!reqReady) @(negedge clk);
    rdBase = nRd; wrBase = nWr;
    reqValid = 1'b1; reqWrite = w; reqSize = sz; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    readyAfterAccept = reqReady;
    while (!rspValid) @(negedge clk);
    rd = rspRdata;
  endtask

  function automatic int readyDelta();
    return cyc - lastWrCyc;
  endfunction

  task automatic testReset();
    logic [31:0] rd;
    chk("R11 ready after reset", 32'(reqReady), 1);
    chk("R11 dnValid idle", 32'(dnValid), 0);
    chk("R11 rspValid idle", 32'(rspValid), 0);
    doReq(0, 2'd1, 8'h0C, 0, rd);
    chk("R11 xfer shadow invalid: read goes down", 32'(nRd - rdBase), 1);
    chk("R11 xfer read value", rd, {16'h0, initWord(3)[15:0]});
  endtask

  task automatic testWordWrite();
    logic [31:0] rd;
    doReq(1, 2'd2, 8'h20, 32'h1122_3344, rd);
    chk("R12 ready low after accept", 32'(readyAfterAccept), 0);
    chk("R3 no read", 32'(nRd - rdBase), 0);
    chk("R3 one write", 32'(nWr - wrBase), 1);
    chk("R3 write addr", 32'(lastWrAddr), 32'h20);
    chk("R3 write data", lastWrData, 32'h1122_3344);
  endtask

  task automatic testByteWrite();
    logic [31:0] rd;
    doReq(1, 2'd0, 8'h22, 32'hBE, rd);
    chk("R1 one read", 32'(nRd - rdBase), 1);
    chk("R1 lane 2 merged", lastWrData, 32'h11BE_3344);
    doReq(1, 2'd0, 8'h13, 32'h7E, rd);
    chk("R1 lane 3 addr", 32'(lastWrAddr), 32'h10);
    chk("R1 lane 3 merged", lastWrData, {8'h7E, initWord(4)[23:0]});
  endtask

  task automatic testHalfPlain();
    logic [31:0] rd;
    doReq(1, 2'd1, 8'h1A, 32'hCAFE, rd);
    chk("R2 read then write", 32'((nRd - rdBase) * 16 + (nWr - wrBase)), 32'h11);
    chk("R2 upper half merged", lastWrData, {16'hCAFE, initWord(6)[15:0]});
  endtask

  task automatic testPlainReads();
    logic [31:0] rd;
    doReq(0, 2'd0, 8'h21, 0, rd);
    chk("R7 byte read lane 1", rd, 32'h33);
    doReq(0, 2'd1, 8'h22, 0, rd);
    chk("R7 half read lane 2", rd, 32'h11BE);
    chk("R7 plain read goes down", 32'(nRd - rdBase), 1);
  endtask

  task automatic testBlockShadow();
    logic [31:0] rd;
    doReq(1, 2'd1, 8'h04, 32'h0200, rd);
    chk("R4 first blk write seeds by read", 32'(nRd - rdBase), 1);
    chk("R4 first blk write no write", 32'(nWr - wrBase), 0);
    doReq(1, 2'd1, 8'h06, 32'h0008, rd);
    chk("R4 second blk write no access", 32'((nRd - rdBase) + (nWr - wrBase)), 0);
    doReq(0, 2'd1, 8'h06, 0, rd);
    chk("R7 blk count from shadow", rd, 32'h0008);
    chk("R7 shadow read no access", 32'(nRd - rdBase), 0);
    doReq(0, 2'd1, 8'h04, 0, rd);
    chk("R7 blk size from shadow", rd, 32'h0200);
    doReq(0, 2'd2, 8'h04, 0, rd);
    chk("R4 peripheral word untouched", rd, initWord(1));
  endtask

  task automatic testXferShadow();
    logic [31:0] rd;
    doReq(1, 2'd1, 8'h0C, 32'h0013, rd);
    chk("R5 xfer write reads once", 32'(nRd - rdBase), 1);
    chk("R5 xfer write no write", 32'(nWr - wrBase), 0);
    doReq(0, 2'd1, 8'h0C, 0, rd);
    chk("R7 xfer from shadow", rd, 32'h0013);
    chk("R7 xfer shadow no access", 32'(nRd - rdBase), 0);
    doReq(0, 2'd1, 8'h0E, 0, rd);
    chk("R7 cmd half read goes down", rd, {16'h0, initWord(3)[31:16]});
  endtask

  task automatic testCommand();
    logic [31:0] rd;
    doReq(1, 2'd1, 8'h0E, 32'h1A52, rd);
    chk("R6 two writes", 32'(nWr - wrBase), 2);
    chk("R6 no read", 32'(nRd - rdBase), 0);
    chk("R6 flush addr", 32'(prevWrAddr), 32'h04);
    chk("R6 flush data", prevWrData, 32'h0008_0200);
    chk("R6 cmd addr", 32'(lastWrAddr), 32'h0C);
    chk("R6 cmd data", lastWrData, 32'h1A52_0013);
    chk("R10 flush and cmd back to back", 32'(lastWrCyc - prevWrCyc), 1);
    chk("R10 ready next cycle", 32'(readyDelta()), 1);
    doReq(0, 2'd1, 8'h0C, 0, rd);
    chk("R6 xfer flag cleared", 32'(nRd - rdBase), 1);
    doReq(1, 2'd1, 8'h06, 32'h0009, rd);
    chk("R6 blk flag cleared", 32'(nRd - rdBase), 1);
    doReq(1, 2'd1, 8'h0E, 32'h0D0D, rd);
    chk("R6 reflush data", prevWrData, 32'h0009_0200);
    chk("R6 cmd keeps old xfer", lastWrData, 32'h0D0D_0013);
    doReq(1, 2'd1, 8'h0E, 32'h0101, rd);
    chk("R6 no flush when blk idle", 32'(nWr - wrBase), 1);
    chk("R6 lone cmd data", lastWrData, 32'h0101_0013);
  endtask

  task automatic testSpacing(int hz, int expUs, string req);
    logic [31:0] rd;
    cardHz = 32'(hz);
    doReq(1, 2'd2, 8'h30, 32'(hz), rd);
    while (!reqReady) @(negedge clk);
    chk(req, 32'(readyDelta()), 32'(expUs * 50 + 1));
  endtask

  task automatic testSlowFlush();
    logic [31:0] rd;
    cardHz = 32'd400000;
    doReq(1, 2'd1, 8'h04, 32'h0040, rd);
    doReq(1, 2'd1, 8'h0E, 32'h0202, rd);
    chk("R8 gap between flush and cmd", 32'(lastWrCyc - prevWrCyc), 32'(10 * 50 + 1));
    chk("R8 cmd after gap data", lastWrData, 32'h0202_0013);
    while (!reqReady) @(negedge clk);
    cardHz = 32'd25000000;
    doReq(1, 2'd2, 8'h34, 32'h55, rd);
    chk("R10 fast write no gap", 32'(readyDelta()), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWordWrite();
    testByteWrite();
    testHalfPlain();
    testPlainReads();
    testBlockShadow();
    testXferShadow();
    testCommand();
    testSpacing(400000, 10, "R8 400 kHz gap");
    testSpacing(300000, 14, "R8 300 kHz gap rounds up");
    testSpacing(100000, 40, "R8 100 kHz gap");
    testSpacing(0, 10, "R9 stopped clock gap");
    testSlowFlush();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL R12 watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule